// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is a single interrupt file that collects message-signalled interrupts for a group of interrupt pages. Page 0 serves the supervisor or machine level. Every other page serves one guest. Each page keeps one pending bit and one enable bit for every interrupt identity. It also keeps a one-bit delivery switch and a threshold. A device raises an interrupt by writing the identity number as a 32-bit word to offset 0 of the target page's 4 KiB window in the bus address space. That write sets the identity's pending bit.

For every page, the block keeps a current top interrupt. This is the lowest-numbered identity that is both pending and enabled and that also passes the page's threshold. The page's interrupt line is raised when the delivery switch is on and a top interrupt exists. The hart reads and changes the per-page state through a register access port.

Writing the top-interrupt selector claims the interrupt. The access returns the top value and clears that identity's pending bit, and the write data is ignored. Choosing which privilege level or guest may reach which page is the job of the surrounding logic.

The block has no sequencing state machine. Every page is a set of plain registers, and its next value is decided in the same cycle as the access.

Top module: `msi_intr_file`

## Requirements
- R1: After reset every pending, enable, delivery and threshold bit is zero. All interrupt lines are low, and every register read returns 0.
- R2: Identity 0 is never valid. Its pending and enable bits always read 0, whether it is written through enable/pending word 0 bit 0 or sent as a message.
- R3: A message write is valid when its address has offset 0x000 inside page p's 4 KiB window (page = address bits above bit 11) and p is below NUM_PAGES. If its data d satisfies 1 <= d < NUM_IDS, the write sets pending bit d of page p. Any other data value changes nothing.
- R4: Message writes have no effect in three cases: the offset is any value other than 0x000 (this includes the big-endian word at 0x004), the address is not 4-byte aligned, or the page is at or beyond NUM_PAGES. Message-window read data is always 0.
- R5: Selector 0x02 reads the top value. It is (id << 16) | id, where id is the smallest identity that is both pending and enabled. It is 0 when no identity qualifies.
- R6: A page's threshold T applies when 1 <= T <= NUM_IDS. Only identities below T then qualify. When T is 0 or larger than NUM_IDS, every identity qualifies.
- R7: A write access to selector 0x02 ignores its data. It returns the top value as it was before the access and clears that identity's pending bit. When there is no top interrupt, it changes nothing. Identities that are pending but not enabled are left unchanged.
- R8: irq[p] is high exactly when page p's delivery bit is 1 and page p has a top interrupt. It follows a state change one clock later.
- R9: Selector 0x00 (delivery) stores only bit 0. Selector 0x01 (threshold) stores bits 10:0. Both take each bit from write data only where the write mask bit is 1.
- R10: Selectors 0x40+n and 0x80+n access pending and enable word n, which covers identities 32n..32n+31. A write updates only the bits set in the write mask. Every access returns the prior register value on reg_rdata, with reg_rvalid high, one cycle after reg_en.
- R11: Pages are independent. A message, access or claim aimed at one page never changes another page's state or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Message write strobe |
| msi_addr | input | ADDR_W | Byte address of the message write inside the block window |
| msi_wdata | input | 32 | Message write data (identity number) |
| msi_rdata | output | 32 | Read data of the message window, always zero |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_page | input | PAGE_W | Target page of the access |
| reg_sel | input | 8 | Register selector |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_en |
| reg_rdata | output | 32 | Value of the register before the access |
| irq | output | NUM_PAGES | One interrupt line per page |

## Verification
The embedded properties are checked on every cycle. They cover these points:
- Identity 0 stays clear.
- An accepted message leaves its pending bit set in the next cycle.
- Any reported top identity is both pending and enabled, and lies below an active threshold.
- A claim drops the claimed pending bit.
- A line rises only when delivery was on in the cycle before.
- Misaligned message addresses never reach any page.

Some behaviour can be shown only by the bench's scenarios:
- The exact encoding of the top value.
- Lowest-number priority among several pending identities.
- The threshold boundary cases, including values beyond the identity count.
- The masked field widths of the delivery and threshold registers.
- The one-cycle lag of the lines.
- Page isolation.

// File: rtl/msif_pkg.sv
package msif_pkg;

    localparam int THR_W     = 11;
    localparam int WORD_BITS = 32;
    localparam int FIELD_LSB = 16;

    typedef enum logic [2:0] {
        K_NONE,
        K_DELIV,
        K_THRESH,
        K_TOP,
        K_PEND,
        K_ENAB
    } acc_kind_e;

    function automatic acc_kind_e sel_kind(input logic [7:0] sel);
        acc_kind_e k;
        if (sel == 8'h00)            k = K_DELIV;
        else if (sel == 8'h01)       k = K_THRESH;
        else if (sel == 8'h02)       k = K_TOP;
        else if (sel[7:6] == 2'b01)  k = K_PEND;
        else if (sel[7:6] == 2'b10)  k = K_ENAB;
        else                         k = K_NONE;
        return k;
    endfunction

    function automatic logic [31:0] pack_top(input logic [THR_W-1:0] id);
        logic [31:0] v;
        v = '0;
        v[FIELD_LSB +: THR_W] = id;
        v[0 +: THR_W]         = id;
        return v;
    endfunction

endpackage

// File: rtl/msif_msi_decode.sv
module msif_msi_decode #(
    parameter int NUM_PAGES = 4,
    parameter int NUM_IDS   = 64,
    parameter int ADDR_W    = 16
) (
    input  logic                       valid,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                data,
    output logic [NUM_PAGES-1:0]       set_vec,
    output logic [$clog2(NUM_IDS)-1:0] set_id
);
    localparam int ID_W    = $clog2(NUM_IDS);
    localparam int PG_LSB  = 12;
    localparam int PG_BITS = ADDR_W - PG_LSB;

    logic [PG_BITS-1:0] page;
    logic [11:0]        offset;
    logic               accept;

    always_comb begin
        page   = addr[ADDR_W-1:PG_LSB];
        offset = addr[PG_LSB-1:0];
        accept = valid
              && (offset == 12'h000)
              && (32'(page) < 32'(NUM_PAGES))
              && (data != 32'd0)
              && (data < 32'(NUM_IDS));
        set_id = data[ID_W-1:0];
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_sel
        assign set_vec[p] = accept && (32'(page) == p);
    end

endmodule

// File: rtl/msif_prio.sv
module msif_prio #(
    parameter int NUM_IDS = 64
) (
    input  logic [NUM_IDS-1:0]         cand,
    output logic [$clog2(NUM_IDS)-1:0] win_id,
    output logic                       win_found
);
    localparam int ID_W = $clog2(NUM_IDS);

    always_comb begin
        win_id    = '0;
        win_found = 1'b0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (cand[i]) begin
                win_id    = ID_W'(i);
                win_found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msif_page.sv
module msif_page
    import msif_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msi_set,
    input  logic [$clog2(NUM_IDS)-1:0] msi_id,
    input  logic                       acc_en,
    input  logic                       acc_we,
    input  acc_kind_e                  acc_kind,
    input  logic [5:0]                 acc_word,
    input  logic [31:0]                wdata,
    input  logic [31:0]                wmask,
    output logic [31:0]                rd_val,
    output logic                       irq
);
    localparam int ID_W   = $clog2(NUM_IDS);
    localparam int WORDS  = NUM_IDS / WORD_BITS;
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [NUM_IDS-1:0] pend_q, pend_d;
    logic [NUM_IDS-1:0] en_q, en_d;
    logic               deliv_q, deliv_d;
    logic [THR_W-1:0]   thr_q, thr_d;
    logic               irq_q;

    logic               lim_on;
    logic [NUM_IDS-1:0] cand;
    logic [ID_W-1:0]    top_id;
    logic               top_found;
    logic [31:0]        top_val;
    logic               wr_go;
    logic               word_ok;

    logic [31:0] pend_w [WORDS];
    logic [31:0] en_w   [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_words
        assign pend_w[w] = pend_q[w*WORD_BITS +: WORD_BITS];
        assign en_w[w]   = en_q[w*WORD_BITS +: WORD_BITS];
    end

    // Threshold window and candidate set
    assign lim_on = (thr_q != '0) && (32'(thr_q) <= 32'(NUM_IDS));

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_cand
        assign cand[i] = pend_q[i] && en_q[i] && (!lim_on || (32'(i) < 32'(thr_q)));
    end

    msif_prio #(.NUM_IDS(NUM_IDS)) u_prio (
        .cand      (cand),
        .win_id    (top_id),
        .win_found (top_found)
    );

    assign top_val = top_found ? pack_top(THR_W'(top_id)) : 32'd0;
    assign wr_go   = acc_en && acc_we;
    assign word_ok = 32'(acc_word) < 32'(WORDS);

    // Next-state logic
    always_comb begin
        pend_d  = pend_q;
        en_d    = en_q;
        deliv_d = deliv_q;
        thr_d   = thr_q;
        if (wr_go) begin
            unique case (acc_kind)
                K_DELIV:  deliv_d = (deliv_q & ~wmask[0]) | (wdata[0] & wmask[0]);
                K_THRESH: thr_d   = (thr_q & ~wmask[THR_W-1:0]) | (wdata[THR_W-1:0] & wmask[THR_W-1:0]);
                K_TOP: begin
                    if (top_found) pend_d[top_id] = 1'b0;
                end
                K_PEND: begin
                    for (int i = 0; i < NUM_IDS; i++) begin
                        if ((i / WORD_BITS) == int'(acc_word) && wmask[i % WORD_BITS])
                            pend_d[i] = wdata[i % WORD_BITS];
                    end
                end
                K_ENAB: begin
                    for (int i = 0; i < NUM_IDS; i++) begin
                        if ((i / WORD_BITS) == int'(acc_word) && wmask[i % WORD_BITS])
                            en_d[i] = wdata[i % WORD_BITS];
                    end
                end
                default: ;
            endcase
        end
        if (msi_set) pend_d[msi_id] = 1'b1;
        pend_d[0] = 1'b0;
        en_d[0]   = 1'b0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            en_q    <= '0;
            deliv_q <= 1'b0;
            thr_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            en_q    <= en_d;
            deliv_q <= deliv_d;
            thr_q   <= thr_d;
            irq_q   <= deliv_q && top_found;
        end
    end

    // Read mux
    always_comb begin
        rd_val = 32'd0;
        unique case (acc_kind)
            K_DELIV:  rd_val = {31'd0, deliv_q};
            K_THRESH: rd_val = {{(32-THR_W){1'b0}}, thr_q};
            K_TOP:    rd_val = top_val;
            K_PEND:   rd_val = word_ok ? pend_w[acc_word[WORD_W-1:0]] : 32'd0;
            K_ENAB:   rd_val = word_ok ? en_w[acc_word[WORD_W-1:0]] : 32'd0;
            default:  rd_val = 32'd0;
        endcase
    end

    assign irq = irq_q;

    a_r2_id0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !en_q[0]);

    a_r3_msi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        msi_set |=> pend_q[$past(msi_id)]);

    a_r5_top_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        top_found |-> (pend_q[top_id] && en_q[top_id]));

    a_r6_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (top_found && thr_q != '0 && 32'(thr_q) <= 32'(NUM_IDS)) |-> (32'(top_id) < 32'(thr_q)));

    a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && acc_kind == K_TOP && top_found && !(msi_set && msi_id == top_id))
        |=> !pend_q[$past(top_id)]);

    a_r8_irq_needs_deliv: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(deliv_q));

endmodule

// File: rtl/msi_intr_file.sv
module msi_intr_file
    import msif_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int NUM_IDS   = 64,
    parameter int ADDR_W    = 16,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    input  logic [ADDR_W-1:0]    msi_addr,
    input  logic [31:0]          msi_wdata,
    output logic [31:0]          msi_rdata,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [PAGE_W-1:0]    reg_page,
    input  logic [7:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    input  logic [31:0]          reg_wmask,
    output logic                 reg_rvalid,
    output logic [31:0]          reg_rdata,
    output logic [NUM_PAGES-1:0] irq
);
    localparam int ID_W = $clog2(NUM_IDS);

    logic [NUM_PAGES-1:0] set_vec;
    logic [ID_W-1:0]      set_id;
    acc_kind_e            kind;
    logic                 page_ok;
    logic [31:0]          rd_vals [NUM_PAGES];
    logic [31:0]          rd_mux;
    logic                 rvalid_q;
    logic [31:0]          rdata_q;

    assign msi_rdata = 32'd0;
    assign kind      = sel_kind(reg_sel);
    assign page_ok   = 32'(reg_page) < 32'(NUM_PAGES);

    msif_msi_decode #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_IDS   (NUM_IDS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .valid   (msi_valid),
        .addr    (msi_addr),
        .data    (msi_wdata),
        .set_vec (set_vec),
        .set_id  (set_id)
    );

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        msif_page #(.NUM_IDS(NUM_IDS)) u_page (
            .clk      (clk),
            .rst_n    (rst_n),
            .msi_set  (set_vec[p]),
            .msi_id   (set_id),
            .acc_en   (reg_en && (32'(reg_page) == p)),
            .acc_we   (reg_we),
            .acc_kind (kind),
            .acc_word (reg_sel[5:0]),
            .wdata    (reg_wdata),
            .wmask    (reg_wmask),
            .rd_val   (rd_vals[p]),
            .irq      (irq[p])
        );
    end

    assign rd_mux = page_ok ? rd_vals[reg_page] : 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= reg_en;
            rdata_q  <= reg_en ? rd_mux : 32'd0;
        end
    end

    assign reg_rvalid = rvalid_q;
    assign reg_rdata  = rdata_q;

    a_r4_misaligned_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_addr[1:0] != 2'b00) |-> (set_vec == '0));

    a_r4_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        msi_rdata == 32'd0);

    a_r3_one_page: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

endmodule

// File: tb/sim_msi_intr_file.sv
module sim_msi_intr_file;

    localparam int NP = 4;
    localparam int NI = 64;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msi_valid = 1'b0;
    logic [AW-1:0] msi_addr = '0;
    logic [31:0]   msi_wdata = '0;
    logic [31:0]   msi_rdata;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_page = '0;
    logic [7:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_wmask = '0;
    logic          reg_rvalid;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          chk;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    msi_intr_file #(.NUM_PAGES(NP), .NUM_IDS(NI), .ADDR_W(AW)) u0 (
        .clk, .rst_n, .msi_valid, .msi_addr, .msi_wdata, .msi_rdata,
        .reg_en, .reg_we, .reg_page, .reg_sel, .reg_wdata, .reg_wmask,
        .reg_rvalid, .reg_rdata, .irq
    );

    // Monitor: pops scoreboard items as read data appears
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: unexpected rvalid, got %h expected none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (it.chk) begin
                    n_cmp++;
                    if (reg_rdata !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic acc(input logic [1:0] pg, input logic [7:0] sel, input bit we,
                       input logic [31:0] wd, input logic [31:0] wm,
                       input logic [31:0] exp, input bit chk, input string tag);
        item_t it;
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_page = pg; reg_sel = sel;
        reg_wdata = wd; reg_wmask = wm;
        it.exp = exp; it.chk = chk; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] pg, input logic [7:0] sel,
                      input logic [31:0] exp, input string tag);
        acc(pg, sel, 1'b0, 32'd0, 32'd0, exp, 1'b1, tag);
    endtask

    task automatic wr(input logic [1:0] pg, input logic [7:0] sel,
                      input logic [31:0] wd, input logic [31:0] wm);
        acc(pg, sel, 1'b1, wd, wm, 32'd0, 1'b0, "wr");
    endtask

    task automatic msi(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_wdata = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic chk_irq_now(input logic [NP-1:0] exp, input string tag);
        n_cmp++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic chk_irq(input logic [NP-1:0] exp, input string tag);
        @(negedge clk);
        chk_irq_now(exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(4'b0000, "R1 irq after reset");
        rd(2'd0, 8'h00, 32'd0, "R1 delivery reset");
        rd(2'd0, 8'h02, 32'd0, "R1 top reset");
        rd(2'd3, 8'h01, 32'd0, "R1 threshold reset");
        n_cmp++;
        if (msi_rdata !== 32'd0) begin
            n_bad++; $display("FAIL R4: msi_rdata got %h expected 0", msi_rdata);
        end

        // R2 / R10 enable words
        wr(2'd0, 8'h80, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(2'd0, 8'h80, 32'hFFFF_FFFE, "R2 id0 enable stuck");
        wr(2'd0, 8'h81, 32'h0000_00FF, 32'h0000_000F);
        rd(2'd0, 8'h81, 32'h0000_000F, "R10 masked enable write");

        // R3 message sets pending, R5 top encoding
        msi(16'h0000, 32'd5);
        rd(2'd0, 8'h40, 32'h0000_0020, "R3 msi sets pending 5");
        rd(2'd0, 8'h02, 32'h0005_0005, "R5 top encoding id5");
        chk_irq(4'b0000, "R8 no irq without delivery");

        // R2/R3/R4 ignored messages
        msi(16'h0000, 32'd0);
        msi(16'h0000, 32'd64);
        msi(16'h0004, 32'd3);
        msi(16'h0002, 32'd3);
        msi(16'h0008, 32'd3);
        msi(16'h4000, 32'd3);
        rd(2'd0, 8'h40, 32'h0000_0020, "R4 ignored msi word0");
        rd(2'd0, 8'h41, 32'h0000_0000, "R3 out of range id word1");

        // R9 delivery, R8 line timing
        wr(2'd0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk_irq_now(4'b0000, "R8 irq one cycle later");
        chk_irq(4'b0001, "R8 irq rises");
        rd(2'd0, 8'h00, 32'h0000_0001, "R9 delivery one bit");

        // R5 priority among several
        msi(16'h0000, 32'd3);
        msi(16'h0000, 32'd33);
        msi(16'h0000, 32'd40);
        rd(2'd0, 8'h02, 32'h0003_0003, "R5 lowest id wins");
        rd(2'd0, 8'h41, 32'h0000_0102, "R3 pending word1");

        // R6 threshold behaviour, R9 masking
        wr(2'd0, 8'h01, 32'hFFFF_F003, 32'hFFFF_FFFF);
        rd(2'd0, 8'h01, 32'h0000_0003, "R9 threshold masked");
        rd(2'd0, 8'h02, 32'h0000_0000, "R6 threshold 3 hides 3");
        chk_irq(4'b0000, "R8 irq drops with threshold");
        wr(2'd0, 8'h01, 32'd4, 32'hFFFF_FFFF);
        rd(2'd0, 8'h02, 32'h0003_0003, "R6 threshold 4 shows 3");
        wr(2'd0, 8'h01, 32'd65, 32'hFFFF_FFFF);
        rd(2'd0, 8'h02, 32'h0003_0003, "R6 threshold above count");
        wr(2'd0, 8'h01, 32'd0, 32'hFFFF_FFFF);
        rd(2'd0, 8'h02, 32'h0003_0003, "R6 threshold zero");

        // R7 claims
        acc(2'd0, 8'h02, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0003_0003, 1'b1, "R7 claim 3");
        acc(2'd0, 8'h02, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0005_0005, 1'b1, "R7 claim 5");
        acc(2'd0, 8'h02, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0021_0021, 1'b1, "R7 claim 33");
        acc(2'd0, 8'h02, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R7 claim none");
        rd(2'd0, 8'h40, 32'h0000_0000, "R7 word0 cleared");
        rd(2'd0, 8'h41, 32'h0000_0100, "R7 disabled id40 kept");
        chk_irq(4'b0000, "R8 irq low after claims");

        // R11 page isolation
        msi(16'h2000, 32'd7);
        wr(2'd2, 8'h80, 32'h0000_0080, 32'h0000_0080);
        wr(2'd2, 8'h00, 32'd1, 32'd1);
        chk_irq(4'b0100, "R11 page2 irq only");
        rd(2'd2, 8'h02, 32'h0007_0007, "R11 page2 top");
        rd(2'd0, 8'h02, 32'h0000_0000, "R11 page0 top untouched");
        rd(2'd1, 8'h40, 32'h0000_0000, "R11 page1 pending untouched");

        // R9 mask on delivery
        wr(2'd2, 8'h00, 32'd0, 32'd0);
        rd(2'd2, 8'h00, 32'd1, "R9 delivery unmasked write ignored");
        wr(2'd2, 8'h00, 32'd0, 32'd1);
        rd(2'd2, 8'h00, 32'd0, "R9 delivery cleared");
        chk_irq(4'b0000, "R8 irq drops with delivery");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule